// File: doc/BRIEF.md
# Token-Passing Guarded-Transition State Machine

This block is a small controller with two states, a home state and an away state. It sits quietly in its home state until a one-cycle start pulse hands it the token. It then decides on every enabled clock edge where to go next. Each state carries an ordered list of guards on the boolean inputs. The first guard that holds picks the next state and the value of every registered output bit. If no guard holds and the state has no catch-all, the machine stays put and drives all outputs low.

When a started machine travels from the away state back to home, it raises a one-cycle finish pulse, drops its token and goes idle. The finish pulse can feed the start input of the next controller in a chain. An enable input freezes the whole machine. A parameter can tie that enable permanently high.

The rule set is fixed. In home: if `in_a` is high, go away with q=1, r=0; otherwise stay home with q=1, r=1. In away: if `in_a` is low, return home with q=0, r=1; else if `in_b` is high, stay away with q=1, r=1. There is no catch-all in away.

Top module: `tok_fsm`

## Requirements
- R1: Synchronous active-high reset leaves the machine home and idle, with out_q, out_r and fin all 0.
- R2: While idle and without a start pulse, out_q, out_r and fin stay 0 whatever in_a and in_b do.
- R3: A start pulse on an enabled edge while idle arms the machine, and the home rules are applied on that same edge.
- R4: In home while running: in_a=1 moves to away with q=1, r=0; otherwise it stays home with q=1, r=1.
- R5: In away, in_a=0 returns home with q=0, r=1. This guard wins over the in_b guard.
- R6: In away with in_a=1: in_b=1 stays away with q=1, r=1. With in_b=0 no guard holds, so the machine stays away with q=0, r=0.
- R7: fin is high for exactly the one cycle after the away-to-home return edge. The machine is then idle, and without a new start its outputs are 0 on the following edge.
- R8: A start pulse while running, including on the return edge itself, is ignored and does not re-arm the machine.
- R9: A start pulse during the cycle fin is high is accepted and starts a new run.
- R10: With enable low, state, outputs and the running flag hold their values, fin is 0 and a start pulse is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Stall control, high to advance |
| go | input | 1 | Start token, one-cycle pulse |
| in_a | input | 1 | First guard input |
| in_b | input | 1 | Second guard input |
| out_q | output | 1 | Registered output q |
| out_r | output | 1 | Registered output r |
| fin | output | 1 | One-cycle token hand-off pulse |

## Verification
Two events can meet on one edge: a new start token and the end of the current run. The first case is a start pulse that arrives on the away-to-home return edge, while the machine still holds the token. That pulse must be dropped, so the outputs fall to 0 one edge later. The second case is a start pulse during the cycle fin is high. That pulse must be taken, so the home rules drive the outputs on the next edge. Both orderings are driven directly, and the judgement is made at the outputs one edge after each collision.

// File: rtl/tok_fsm_pkg.sv
package tok_fsm_pkg;
    localparam int NIN  = 2;
    localparam int NOUT = 2;
    localparam int IDX_A = 0;
    localparam int IDX_B = 1;
    localparam int IDX_Q = 1;
    localparam int IDX_R = 0;

    typedef enum logic [0:0] {
        ST_HOME = 1'b0,
        ST_AWAY = 1'b1
    } tok_state_e;

    typedef struct packed {
        tok_state_e      state;
        logic            run;
        logic [NOUT-1:0] outs;
        logic            fin;
    } tok_regs_t;
endpackage

// File: rtl/tok_fsm_rules.sv
module tok_fsm_rules
    import tok_fsm_pkg::*;
(
    input  tok_state_e      cur,
    input  logic [NIN-1:0]  ins,
    output tok_state_e      nxt,
    output logic [NOUT-1:0] outs
);
    always_comb begin
        // implicit catch-all: hold state, all outputs low
        nxt  = cur;
        outs = '0;
        unique case (cur)
            ST_HOME: begin
                if (ins[IDX_A]) begin
                    nxt         = ST_AWAY;
                    outs[IDX_Q] = 1'b1;
                    outs[IDX_R] = 1'b0;
                end else begin
                    nxt         = ST_HOME;
                    outs[IDX_Q] = 1'b1;
                    outs[IDX_R] = 1'b1;
                end
            end
            ST_AWAY: begin
                if (!ins[IDX_A]) begin
                    nxt         = ST_HOME;
                    outs[IDX_Q] = 1'b0;
                    outs[IDX_R] = 1'b1;
                end else if (ins[IDX_B]) begin
                    nxt         = ST_AWAY;
                    outs[IDX_Q] = 1'b1;
                    outs[IDX_R] = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tok_fsm_token.sv
module tok_fsm_token
    import tok_fsm_pkg::*;
(
    input  logic       go,
    input  logic       run_q,
    input  tok_state_e cur,
    input  tok_state_e nxt,
    output logic       active,
    output logic       ret
);
    always_comb begin
        // a start pulse only matters while idle; when running it is absorbed
        active = run_q || go;
        ret    = active && (cur == ST_AWAY) && (nxt == ST_HOME);
    end
endmodule

// File: rtl/tok_fsm.sv
module tok_fsm
    import tok_fsm_pkg::*;
#(
    parameter bit USE_EN = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic go,
    input  logic in_a,
    input  logic in_b,
    output logic out_q,
    output logic out_r,
    output logic fin
);
    tok_regs_t       st_d, st_q;
    logic            en_eff;
    tok_state_e      rule_nxt;
    logic [NOUT-1:0] rule_outs;
    logic            active, ret;
    logic [NIN-1:0]  ins;

    generate
        if (USE_EN) begin : g_en
            assign en_eff = en;
        end else begin : g_tied
            assign en_eff = 1'b1;
        end
    endgenerate

    assign ins[IDX_A] = in_a;
    assign ins[IDX_B] = in_b;

    tok_fsm_rules u_rules (
        .cur  (st_q.state),
        .ins  (ins),
        .nxt  (rule_nxt),
        .outs (rule_outs)
    );

    tok_fsm_token u_token (
        .go     (go),
        .run_q  (st_q.run),
        .cur    (st_q.state),
        .nxt    (rule_nxt),
        .active (active),
        .ret    (ret)
    );

    always_comb begin
        st_d     = st_q;
        st_d.fin = 1'b0;
        if (en_eff) begin
            if (active) begin
                st_d.state = rule_nxt;
                st_d.outs  = rule_outs;
                st_d.fin   = ret;
                st_d.run   = !ret;
            end else begin
                st_d.outs = '0;
                st_d.run  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.state <= ST_HOME;
            st_q.run   <= 1'b0;
            st_q.outs  <= '0;
            st_q.fin   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_q = st_q.outs[IDX_Q];
    assign out_r = st_q.outs[IDX_R];
    assign fin   = st_q.fin;
endmodule

// File: rtl/tok_fsm_chk.sv
module tok_fsm_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic go,
    input logic in_a,
    input logic in_b,
    input logic out_q,
    input logic out_r,
    input logic fin
);
    AST_FIN_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fin |=> !fin); // R7
    AST_FIN_RETURN_OUTS: assert property (@(posedge clk) disable iff (rst)
        fin |-> (!out_q && out_r)); // R5
    AST_IDLE_AFTER_FIN: assert property (@(posedge clk) disable iff (rst)
        (fin && en && !go) |=> (!out_q && !out_r)); // R7
    AST_RESTART_ON_FIN: assert property (@(posedge clk) disable iff (rst)
        (fin && en && go && in_a) |=> (out_q && !out_r && !fin)); // R9
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(out_q) && $stable(out_r))); // R10
    AST_STALL_NO_FIN: assert property (@(posedge clk) disable iff (rst)
        !en |=> !fin); // R10
endmodule

bind tok_fsm tok_fsm_chk u_chk (.*);

// File: tb/tok_fsm_tb.sv
module tok_fsm_tb;
    logic clk = 1'b0;
    logic rst, en, go, in_a, in_b;
    logic out_q, out_r, fin;
    int   n_chk  = 0;
    int   n_fail = 0;

    always #5 clk = ~clk;

    tok_fsm u_dut (
        .clk(clk), .rst(rst), .en(en), .go(go), .in_a(in_a), .in_b(in_b),
        .out_q(out_q), .out_r(out_r), .fin(fin)
    );

    task automatic cyc(input logic e, input logic g, input logic a, input logic b);
        @(negedge clk);
        en = e; go = g; in_a = a; in_b = b;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic eq, input logic er, input logic ef);
        n_chk++;
        if (out_q !== eq || out_r !== er || fin !== ef) begin
            n_fail++;
            $display("FAIL %s: q/r/fin actual %b%b%b expected %b%b%b",
                     req, out_q, out_r, fin, eq, er, ef);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; en = 1'b1; go = 1'b0; in_a = 1'b1; in_b = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", 0, 0, 0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_idle();
        cyc(1, 0, 1, 0); chk("R2", 0, 0, 0);
        cyc(1, 0, 0, 1); chk("R2", 0, 0, 0);
        cyc(1, 0, 1, 1); chk("R2", 0, 0, 0);
    endtask

    task automatic t_full_run();
        cyc(1, 1, 0, 0); chk("R3", 1, 1, 0);
        cyc(1, 0, 0, 0); chk("R4", 1, 1, 0);
        cyc(1, 0, 1, 0); chk("R4", 1, 0, 0);
        cyc(1, 0, 1, 0); chk("R6", 0, 0, 0);
        cyc(1, 0, 1, 1); chk("R6", 1, 1, 0);
        cyc(1, 0, 0, 1); chk("R5", 0, 1, 1);
        cyc(1, 0, 1, 1); chk("R7", 0, 0, 0);
        cyc(1, 0, 0, 0); chk("R7", 0, 0, 0);
    endtask

    task automatic t_go_on_return();
        cyc(1, 1, 1, 0); chk("R3", 1, 0, 0);
        cyc(1, 1, 1, 1); chk("R8", 1, 1, 0);
        cyc(1, 1, 0, 0); chk("R8", 0, 1, 1);
        cyc(1, 0, 1, 0); chk("R8", 0, 0, 0);
    endtask

    task automatic t_go_on_fin();
        cyc(1, 1, 1, 0); chk("R3", 1, 0, 0);
        cyc(1, 0, 0, 0); chk("R7", 0, 1, 1);
        cyc(1, 1, 1, 0); chk("R9", 1, 0, 0);
        cyc(1, 0, 0, 0); chk("R9", 0, 1, 1);
        cyc(1, 0, 0, 0); chk("R7", 0, 0, 0);
    endtask

    task automatic t_stall();
        cyc(0, 1, 1, 0); chk("R10", 0, 0, 0);
        cyc(1, 0, 1, 0); chk("R10", 0, 0, 0);
        cyc(1, 1, 1, 0); chk("R3", 1, 0, 0);
        cyc(0, 0, 0, 0); chk("R10", 1, 0, 0);
        cyc(0, 0, 0, 1); chk("R10", 1, 0, 0);
        cyc(0, 1, 1, 1); chk("R10", 1, 0, 0);
        cyc(1, 0, 0, 0); chk("R10", 0, 1, 1);
        cyc(0, 0, 0, 0); chk("R10", 0, 1, 0);
        cyc(1, 0, 1, 0); chk("R10", 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_full_run();
        t_go_on_return();
        t_go_on_fin();
        t_stall();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule